// File: doc/BRIEF.md
# Time-of-Day Counter with Leap Second Handling

This block keeps the time of day as hours, minutes and seconds and moves it forward by one second each time its tick input is high on a clock edge. Software or a timing front end can prepare a leap-second event ahead of time. The event takes effect only during the final minute of the day.

A prepared insertion stretches that minute to 61 seconds: 23:59:59 is followed by 23:59:60 and then by midnight. A prepared deletion shortens the minute to 59 seconds: 23:59:58 goes straight to midnight. In every other minute the seconds wrap after 59 as usual. Once an event has been applied, its prepared flag clears itself.

A load strobe sets the time directly. A load with a field out of range is refused. The time is given both as binary fields and as two-digit BCD. A one-cycle pulse marks each step into midnight.

Top module: `tod_leap_counter`

## Requirements
- R1: After reset the time is 00:00:00, both pending flags are low and every pulse output is low.
- R2: A tick with no load adds one second. Seconds wrap from 59 to 0 and carry into the minutes. Minutes wrap from 59 to 0 and carry into the hours. A cycle without a tick leaves the time unchanged. The new value appears on the edge where the tick is sampled.
- R3: With nothing pending, a tick at 23:59:59 gives 00:00:00.
- R4: With an insertion pending, a tick at 23:59:59 gives 23:59:60, and the next tick gives 00:00:00. The insertion flag clears on that second step. A seconds value of 60 occurs only at hour 23, minute 59.
- R5: With a deletion pending, a tick at 23:59:58 gives 00:00:00, and the deletion flag clears on that step.
- R6: Outside hour 23, minute 59, a pending flag has no effect on the count. It stays set until it is applied.
- R7: If arm_insert and arm_delete are high in the same cycle, neither flag changes, and arm_conflict is high for one cycle after that edge.
- R8: A valid load replaces all three fields on the next edge and takes priority over a tick in the same cycle. A load leaves the pending flags as they were.
- R9: A load with hour above 23, or minute or second above 59, leaves the time unchanged, and load_error is high for one cycle after that edge.
- R10: Each BCD output carries the tens digit in bits 7:4 and the units digit in bits 3:0 of its binary field.
- R11: day_rollover is high for exactly one cycle after each tick that takes the time to 00:00:00. It is never high after a load.
- R12: Arming one kind of leap event clears the other kind if it is pending. Both pending flags are never high at the same time. A flag that is cleared by being applied and armed again on the same edge stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance strobe |
| load | input | 1 | Load strobe for the time fields |
| load_hour | input | 5 | Hour value to load |
| load_minute | input | 6 | Minute value to load |
| load_second | input | 6 | Second value to load |
| arm_insert | input | 1 | Prepare a leap-second insertion |
| arm_delete | input | 1 | Prepare a leap-second deletion |
| hour | output | 5 | Binary hour |
| minute | output | 6 | Binary minute |
| second | output | 6 | Binary second, up to 60 |
| hour_bcd | output | 8 | BCD hour |
| minute_bcd | output | 8 | BCD minute |
| second_bcd | output | 8 | BCD second |
| day_rollover | output | 1 | One-cycle pulse on entering midnight |
| insert_pending | output | 1 | Insertion is prepared |
| delete_pending | output | 1 | Deletion is prepared |
| arm_conflict | output | 1 | One-cycle pulse after both arms were high together |
| load_error | output | 1 | One-cycle pulse after a refused load |

## Verification
Each field and each flag is a register that drives an output directly, so a wrong internal value shows up on the port in the cycle right after the faulty edge. The bench compares every port with its own model on every clock, so any divergence is seen at once. The exception is a pending flag that is set when it should not be. That fault shows at the port immediately, but its effect on the count stays hidden until the next end-of-day minute. For that reason the bench drives the time through 23:59:58 and 23:59:59 under every flag combination. It also checks that a pending flag survives through other minutes unchanged.

// File: rtl/tod_leap_counter.sv
module tod_leap_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [4:0] load_hour,
  input  logic [5:0] load_minute,
  input  logic [5:0] load_second,
  input  logic       arm_insert,
  input  logic       arm_delete,
  output logic [4:0] hour,
  output logic [5:0] minute,
  output logic [5:0] second,
  output logic [7:0] hour_bcd,
  output logic [7:0] minute_bcd,
  output logic [7:0] second_bcd,
  output logic       day_rollover,
  output logic       insert_pending,
  output logic       delete_pending,
  output logic       arm_conflict,
  output logic       load_error
);

  function automatic logic [7:0] to_bcd(input logic [5:0] v);
    logic [5:0] t, u;
    t = v / 6'd10;
    u = v - t * 6'd10;
    return {t[3:0], u[3:0]};
  endfunction

  logic last_min, load_ok, step, to_leap, from_leap, early_end, sec_wrap, min_wrap, hour_wrap;

  assign last_min  = (hour == 5'd23) && (minute == 6'd59);
  assign load_ok   = (load_hour < 5'd24) && (load_minute < 6'd60) && (load_second < 6'd60);
  assign step      = tick && !load;
  assign from_leap = second == 6'd60;
  assign to_leap   = insert_pending && last_min && (second == 6'd59);
  assign early_end = delete_pending && last_min && (second == 6'd58);
  assign sec_wrap  = second == 6'd59;
  assign min_wrap  = minute == 6'd59;
  assign hour_wrap = hour == 5'd23;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hour <= '0;
      minute <= '0;
      second <= '0;
      day_rollover <= 1'b0;
      load_error <= 1'b0;
    end else begin
      day_rollover <= 1'b0;
      load_error <= 1'b0;
      if (load) begin
        if (load_ok) begin
          hour <= load_hour;
          minute <= load_minute;
          second <= load_second;
        end else begin
          load_error <= 1'b1;
        end
      end else if (tick) begin
        if (from_leap || early_end) begin
          hour <= '0;
          minute <= '0;
          second <= '0;
          day_rollover <= 1'b1;
        end else if (to_leap) begin
          second <= 6'd60;
        end else if (!sec_wrap) begin
          second <= second + 6'd1;
        end else begin
          second <= '0;
          if (!min_wrap) begin
            minute <= minute + 6'd1;
          end else begin
            minute <= '0;
            if (!hour_wrap) begin
              hour <= hour + 5'd1;
            end else begin
              hour <= '0;
              day_rollover <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      insert_pending <= 1'b0;
      delete_pending <= 1'b0;
      arm_conflict <= 1'b0;
    end else begin
      arm_conflict <= arm_insert && arm_delete;
      if (arm_insert && !arm_delete) begin
        insert_pending <= 1'b1;
        delete_pending <= 1'b0;
      end else if (arm_delete && !arm_insert) begin
        delete_pending <= 1'b1;
        insert_pending <= 1'b0;
      end else begin
        if (step && from_leap) insert_pending <= 1'b0;
        if (step && early_end) delete_pending <= 1'b0;
      end
    end
  end

  assign hour_bcd   = to_bcd({1'b0, hour});
  assign minute_bcd = to_bcd(minute);
  assign second_bcd = to_bcd(second);

  p_leap_place_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (second == 6'd60) |-> (hour == 5'd23 && minute == 6'd59));
  p_roll_midnight_r11: assert property (@(posedge clk) disable iff (!rst_n)
    day_rollover |-> (hour == 5'd0 && minute == 6'd0 && second == 6'd0));
  p_roll_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    day_rollover |=> !day_rollover);
  p_pend_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(insert_pending && delete_pending));
  p_reject_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_error |-> (hour == $past(hour) && minute == $past(minute) && second == $past(second)));
  p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (second <= 6'd60 && minute <= 6'd59 && hour <= 5'd23));

endmodule

// File: tb/test_tod_leap_counter.sv
module test_tod_leap_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, load = 1'b0, arm_insert = 1'b0, arm_delete = 1'b0;
  logic [4:0] load_hour = '0;
  logic [5:0] load_minute = '0, load_second = '0;
  logic [4:0] hour;
  logic [5:0] minute, second;
  logic [7:0] hour_bcd, minute_bcd, second_bcd;
  logic day_rollover, insert_pending, delete_pending, arm_conflict, load_error;

  int checks = 0, failures = 0;
  string tag = "R1";
  int eh = 0, em = 0, es = 0, eins = 0, edel = 0, eroll = 0, econf = 0, elerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tod_leap_counter i_tod_leap_counter (.*);

  function automatic int bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      eh = 0; em = 0; es = 0; eins = 0; edel = 0; eroll = 0; econf = 0; elerr = 0;
    end else begin
      eroll = 0; econf = 0; elerr = 0;
      if (load) begin
        if (load_hour < 24 && load_minute < 60 && load_second < 60) begin
          eh = load_hour; em = load_minute; es = load_second;
        end else elerr = 1;
      end else if (tick) begin
        if (es == 60) begin
          eh = 0; em = 0; es = 0; eroll = 1; eins = 0;
        end else if (edel == 1 && eh == 23 && em == 59 && es == 58) begin
          eh = 0; em = 0; es = 0; eroll = 1; edel = 0;
        end else if (eins == 1 && eh == 23 && em == 59 && es == 59) begin
          es = 60;
        end else begin
          es++;
          if (es == 60) begin
            es = 0; em++;
            if (em == 60) begin
              em = 0; eh++;
              if (eh == 24) begin eh = 0; eroll = 1; end
            end
          end
        end
      end
      if (arm_insert && arm_delete) econf = 1;
      else if (arm_insert) begin eins = 1; edel = 0; end
      else if (arm_delete) begin edel = 1; eins = 0; end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("hour", hour, eh);
      chk("minute", minute, em);
      chk("second", second, es);
      chk("ins_pend", insert_pending, eins);
      chk("del_pend", delete_pending, edel);
      chk("day_rollover R11", day_rollover, eroll);
      chk("arm_conflict R7", arm_conflict, econf);
      chk("load_error R9", load_error, elerr);
      chk("hour_bcd R10", hour_bcd, bcd(eh));
      chk("minute_bcd R10", minute_bcd, bcd(em));
      chk("second_bcd R10", second_bcd, bcd(es));
    end
  end

  task automatic cyc(bit t, bit l = 0, int h = 0, int m = 0, int s = 0, bit ai = 0, bit ad = 0);
    @(negedge clk);
    tick = t; load = l; load_hour = 5'(h); load_minute = 6'(m); load_second = 6'(s);
    arm_insert = ai; arm_delete = ad;
  endtask

  task automatic set_time(int h, int m, int s);
    cyc(0, 1, h, m, s);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    cyc(0); cyc(0);
    tag = "R2";
    for (int i = 0; i < 70; i++) cyc(i % 3 != 0);
    set_time(0, 59, 58); cyc(1); cyc(1); cyc(0); cyc(1);
    set_time(9, 59, 59); cyc(1); cyc(0);
    tag = "R3";
    set_time(23, 59, 57); cyc(1); cyc(1); cyc(1); cyc(0); cyc(1);
    tag = "R6";
    cyc(0, 0, 0, 0, 0, 1, 0);
    set_time(12, 30, 58); cyc(1); cyc(1); cyc(1);
    set_time(23, 58, 59); cyc(1); cyc(0);
    tag = "R4";
    set_time(23, 59, 58); cyc(1); cyc(1); cyc(0); cyc(1); cyc(1); cyc(0);
    set_time(23, 59, 59); cyc(1); cyc(1);
    tag = "R5";
    cyc(0, 0, 0, 0, 0, 0, 1);
    set_time(12, 30, 57); cyc(1); cyc(1); cyc(1);
    set_time(23, 59, 57); cyc(1); cyc(1); cyc(0); cyc(1); cyc(0);
    tag = "R7";
    cyc(0, 0, 0, 0, 0, 1, 1); cyc(0);
    cyc(0, 0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0, 1, 1); cyc(0);
    tag = "R12";
    cyc(0, 0, 0, 0, 0, 0, 1); cyc(0);
    set_time(23, 59, 59); cyc(1);
    cyc(1, 0, 0, 0, 0, 1, 0); cyc(0);
    cyc(1); cyc(0);
    tag = "R8";
    cyc(1, 1, 5, 6, 7); cyc(0); cyc(1, 1, 23, 59, 59, 0, 1); cyc(1);
    tag = "R9";
    cyc(0, 1, 24, 0, 0); cyc(1, 1, 1, 60, 0); cyc(0, 1, 2, 3, 60); cyc(0, 1, 31, 63, 63); cyc(1);
    tag = "R2";
    set_time(22, 58, 0);
    for (int i = 0; i < 7500; i++) cyc(1, 0, 0, 0, 0, i == 3000, 0);
    cyc(0); cyc(0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule